// File: doc/BRIEF.md
# Daisy-Chained Converter Readout Sequencer

This block is an SPI master that brings up a pair of delta-sigma converters whose serial outputs are chained, then reads them continuously. After a system reset or a soft restart it holds the converters' shared reset/power-down line low and waits out a settle time after releasing it. Only then does it clock anything. It next sends a fixed register-write command that turns on per-word CRC, followed by a fixed register-dump command. The bytes returned by the dump are captured and checked, and the result is exposed on a readback port.

Once configuration is done, the sequencer raises the conversion-start line and loops on the data-ready input. Every falling edge of data-ready starts a guard delay. After the delay it clocks one combined frame of eight bytes. The first 32 bits shifted in belong to the converter nearest the master, and the next 32 bits belong to the far converter. Each 32-bit word has 24 data bits followed by a CRC byte, and each word is presented with its own valid pulse. The guard delay keeps the first SCLK edge from arriving too early, which would drop the first byte. A data-ready fall that arrives while a frame is still pending raises a sticky overrun flag, and the pending frame still finishes.

Top module: `adc_chain_seq`

## Requirements
- R1: After reset or soft restart, adcResetN is held low for RESET_HOLD clock cycles while adcStart is low and sclk stays low. csN is driven low once reset is released. No SCLK pulse is issued for at least RESET_WAIT cycles after adcResetN rises.
- R2: The first frame sends the bytes 0x41, 0x00, 0x01 in that order, MSB first.
- R3: The second frame sends 0x20, 0x07 and then eight 0x00 bytes. The eight bytes returned on miso during those filler bytes appear on rbData, the first returned byte in bits [63:56], and rbValid rises when the frame ends.
- R4: rbError is set when the first returned readback byte is not 0x83 and is clear when it is 0x83. It is only ever set while rbValid is set.
- R5: adcStart rises only after the readback frame has finished and stays high during continuous capture. dataValid never pulses while adcStart is low.
- R6: In capture, the first SCLK rise of a frame comes no earlier than FIRST_EDGE cycles after drdyN falls and no later than FIRST_EDGE + HALF_DIV + 4 cycles after it.
- R7: Each capture frame has exactly 64 SCLK rising edges, and mosi stays low throughout the frame.
- R8: sclk idles low and each high phase lasts HALF_DIV clock cycles. mosi changes only while sclk is low, and miso is sampled on the rising edge, MSB first.
- R9: The first 32 bits of a capture frame are presented on dataWord with dataDev = 0, and the next 32 bits with dataDev = 1. Each word gets a one-cycle dataValid pulse.
- R10: A drdyN fall while a frame is still in its guard delay or being shifted sets overrun. overrun stays set until soft restart or reset, and the frame in flight completes with correct words.
- R11: A one-cycle softRestart pulse drives adcResetN and adcStart low and clears overrun, rbValid and rbError on the next cycle. The full power-up and configuration sequence then runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| softRestart | input | 1 | Synchronous restart of the whole sequence |
| sclk | output | 1 | SPI serial clock, idle low |
| mosi | output | 1 | SPI data to the chain |
| miso | input | 1 | SPI data from the chain |
| csN | output | 1 | Chip select, held low after reset |
| adcResetN | output | 1 | Shared converter reset/power-down, active low |
| adcStart | output | 1 | Shared conversion start |
| drdyN | input | 1 | Data-ready from the chain, active low |
| dataWord | output | WORD_BITS | Received conversion word with CRC byte |
| dataDev | output | DEV_W | Chain position of dataWord |
| dataValid | output | 1 | One-cycle strobe for dataWord |
| rbData | output | 8*RB_BYTES | Bytes captured by the register dump |
| rbValid | output | 1 | rbData holds a completed dump |
| rbError | output | 1 | First dump byte was not the expected value |
| overrun | output | 1 | Sticky: data-ready fell before a frame finished |

## Verification
The bench builds the block with HALF_DIV = 2, RESET_HOLD = 20, RESET_WAIT = 15, CMD_GAP = 6 and FIRST_EDGE = 8. With these values the power-up timing can be counted cycle by cycle, and a whole 64-bit frame takes only about 260 cycles. That makes it practical to run several capture frames with distinct bit patterns, a frame with a deliberate early data-ready fall, and a restart whose dump returns a leading zero byte, all in one short run. A bench model of the chain serves response bits on falling SCLK and records MOSI, so the command bytes, pulse counts and guard delay are all checked at the pins.

// File: rtl/adc_chain_pkg.sv
package adc_chain_pkg;

  localparam logic [7:0] OP_WRITE_CFG  = 8'h41;
  localparam logic [7:0] WRITE_COUNT   = 8'h00;
  localparam logic [7:0] CFG_CRC_ON    = 8'h01;
  localparam logic [7:0] OP_READ_ALL   = 8'h20;
  localparam logic [7:0] RB_FIRST_GOOD = 8'h83;

  localparam int WRITE_BYTES = 3;
  localparam int READ_HDR    = 2;

  typedef enum logic [1:0] {
    FR_WRITE,
    FR_READ,
    FR_DATA
  } frameKind_e;

  typedef struct packed {
    logic       go;
    logic       abort;
    frameKind_e kind;
  } ctrlStrobe_t;

  typedef enum logic [3:0] {
    S_RST_HOLD,
    S_RST_WAIT,
    S_CFG_WRITE,
    S_REG_READ,
    S_START,
    S_WAIT_READY,
    S_GUARD,
    S_SHIFT
  } seqState_e;

endpackage

// File: rtl/adc_chain_ctrl.sv
module adc_chain_ctrl
  import adc_chain_pkg::*;
#(
  parameter int RESET_HOLD = 20,
  parameter int RESET_WAIT = 15,
  parameter int CMD_GAP    = 6,
  parameter int FIRST_EDGE = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        softRestart,
  input  logic        drdyN,
  input  logic        done,
  output ctrlStrobe_t strobe,
  output logic        adcResetN,
  output logic        adcStart,
  output logic        csN,
  output logic        overrun
);

  localparam int CNT_MAX = (RESET_HOLD > RESET_WAIT ? RESET_HOLD : RESET_WAIT) >
                           (CMD_GAP > FIRST_EDGE ? CMD_GAP : FIRST_EDGE) ?
                           (RESET_HOLD > RESET_WAIT ? RESET_HOLD : RESET_WAIT) :
                           (CMD_GAP > FIRST_EDGE ? CMD_GAP : FIRST_EDGE);
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(RESET_HOLD - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(RESET_WAIT - 1);
  localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(CMD_GAP - 1);
  localparam logic [CNT_W-1:0] GUARD_LAST = CNT_W'(FIRST_EDGE - 1);
  localparam logic [CNT_W-1:0] CNT_TOP    = CNT_W'(CNT_MAX);

  seqState_e        state, stateNext;
  logic [CNT_W-1:0] cnt;
  logic             launched;
  logic             drdyS1, drdyS2, drdyPrev;
  logic             readyFall;
  logic             goNow;
  frameKind_e       goKind;

  assign readyFall = drdyPrev & ~drdyS2;

  always_comb begin
    stateNext = state;
    goNow     = 1'b0;
    goKind    = FR_DATA;
    unique case (state)
      S_RST_HOLD: if (cnt == HOLD_LAST) stateNext = S_RST_WAIT;
      S_RST_WAIT: if (cnt == WAIT_LAST) stateNext = S_CFG_WRITE;
      S_CFG_WRITE: begin
        goKind = FR_WRITE;
        if (!launched) goNow = (cnt == GAP_LAST);
        else if (done) stateNext = S_REG_READ;
      end
      S_REG_READ: begin
        goKind = FR_READ;
        if (!launched) goNow = (cnt == GAP_LAST);
        else if (done) stateNext = S_START;
      end
      S_START:      stateNext = S_WAIT_READY;
      S_WAIT_READY: if (readyFall) stateNext = S_GUARD;
      S_GUARD: begin
        if (cnt == GUARD_LAST) begin
          goNow     = 1'b1;
          stateNext = S_SHIFT;
        end
      end
      S_SHIFT: if (done) stateNext = S_WAIT_READY;
      default: stateNext = S_RST_HOLD;
    endcase
    if (softRestart) begin
      stateNext = S_RST_HOLD;
      goNow     = 1'b0;
    end
  end

  assign strobe.go    = goNow;
  assign strobe.kind  = goKind;
  assign strobe.abort = softRestart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_RST_HOLD;
      cnt       <= '0;
      launched  <= 1'b0;
      drdyS1    <= 1'b1;
      drdyS2    <= 1'b1;
      drdyPrev  <= 1'b1;
      adcResetN <= 1'b0;
      adcStart  <= 1'b0;
      csN       <= 1'b1;
      overrun   <= 1'b0;
    end else begin
      drdyS1   <= drdyN;
      drdyS2   <= drdyS1;
      drdyPrev <= drdyS2;
      csN      <= 1'b0;
      state    <= stateNext;
      if (stateNext != state || softRestart) begin
        cnt      <= '0;
        launched <= 1'b0;
      end else begin
        if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
        if (goNow) launched <= 1'b1;
      end
      adcResetN <= (stateNext != S_RST_HOLD);
      adcStart  <= (stateNext == S_START) || (stateNext == S_WAIT_READY) ||
                   (stateNext == S_GUARD) || (stateNext == S_SHIFT);
      if (softRestart) overrun <= 1'b0;
      else if (readyFall && (state == S_GUARD || state == S_SHIFT)) overrun <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_chain_dp.sv
module adc_chain_dp
  import adc_chain_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int DEVICES   = 2,
  parameter int WORD_BITS = 32,
  parameter int RB_BYTES  = 8,
  parameter int DEV_W     = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic                  miso,
  output logic                  sclk,
  output logic                  mosi,
  output logic                  done,
  output logic [WORD_BITS-1:0]  dataWord,
  output logic [DEV_W-1:0]      dataDev,
  output logic                  dataValid,
  output logic [8*RB_BYTES-1:0] rbData,
  output logic                  rbValid,
  output logic                  rbError
);

  localparam int WORD_BYTES = WORD_BITS / 8;
  localparam int DATA_BYTES = DEVICES * WORD_BYTES;
  localparam int READ_BYTES = READ_HDR + RB_BYTES;
  localparam int MAX_BYTES  = DATA_BYTES > READ_BYTES ? DATA_BYTES : READ_BYTES;
  localparam int BYTE_W     = $clog2(MAX_BYTES + 1);
  localparam int DIV_W      = $clog2(HALF_DIV + 1);
  localparam int WB_W       = WORD_BYTES > 1 ? $clog2(WORD_BYTES) : 1;
  localparam int RB_BITS    = 8 * RB_BYTES;
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(HALF_DIV - 1);
  localparam logic [WB_W-1:0]   WB_LAST   = WB_W'(WORD_BYTES - 1);
  localparam logic [BYTE_W-1:0] HDR_LAST  = BYTE_W'(READ_HDR - 1);

  logic                 busy;
  logic [DIV_W-1:0]     divCnt;
  logic [2:0]           bitIdx;
  logic [BYTE_W-1:0]    byteIdx, lastByte;
  frameKind_e           kindR;
  logic [7:0]           txShift, rxShift;
  logic [WORD_BITS-1:0] wordAcc;
  logic [WB_W-1:0]      wordByte;
  logic [DEV_W-1:0]     devIdx;
  logic [RB_BITS-1:0]   rbAcc;
  logic                 tick;

  function automatic logic [7:0] txByte(frameKind_e k, logic [BYTE_W-1:0] idx);
    logic [7:0] b;
    b = 8'h00;
    if (k == FR_WRITE) begin
      if (idx == BYTE_W'(0))      b = OP_WRITE_CFG;
      else if (idx == BYTE_W'(1)) b = WRITE_COUNT;
      else if (idx == BYTE_W'(2)) b = CFG_CRC_ON;
    end else if (k == FR_READ) begin
      if (idx == BYTE_W'(0))      b = OP_READ_ALL;
      else if (idx == BYTE_W'(1)) b = 8'(RB_BYTES - 1);
    end
    return b;
  endfunction

  always_comb begin
    unique case (kindR)
      FR_WRITE: lastByte = BYTE_W'(WRITE_BYTES - 1);
      FR_READ:  lastByte = BYTE_W'(READ_BYTES - 1);
      default:  lastByte = BYTE_W'(DATA_BYTES - 1);
    endcase
  end

  assign tick   = busy && (divCnt == DIV_LAST);
  assign mosi   = busy & txShift[7];
  assign rbData = rbAcc;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.abort) begin
      busy      <= 1'b0;
      sclk      <= 1'b0;
      divCnt    <= '0;
      bitIdx    <= '0;
      byteIdx   <= '0;
      kindR     <= FR_DATA;
      txShift   <= '0;
      rxShift   <= '0;
      wordAcc   <= '0;
      wordByte  <= '0;
      devIdx    <= '0;
      rbAcc     <= '0;
      rbValid   <= 1'b0;
      rbError   <= 1'b0;
      done      <= 1'b0;
      dataValid <= 1'b0;
      dataWord  <= '0;
      dataDev   <= '0;
    end else begin
      done      <= 1'b0;
      dataValid <= 1'b0;
      if (strobe.go && !busy) begin
        busy     <= 1'b1;
        kindR    <= strobe.kind;
        sclk     <= 1'b0;
        divCnt   <= '0;
        bitIdx   <= '0;
        byteIdx  <= '0;
        wordByte <= '0;
        devIdx   <= '0;
        txShift  <= txByte(strobe.kind, '0);
        if (strobe.kind == FR_READ) begin
          rbValid <= 1'b0;
          rbError <= 1'b0;
        end
      end else if (busy) begin
        if (!tick) begin
          divCnt <= divCnt + 1'b1;
        end else begin
          divCnt <= '0;
          sclk   <= ~sclk;
          if (!sclk) begin
            rxShift <= {rxShift[6:0], miso};
          end else if (bitIdx != 3'd7) begin
            bitIdx  <= bitIdx + 1'b1;
            txShift <= {txShift[6:0], 1'b0};
          end else begin
            bitIdx <= '0;
            if (kindR == FR_DATA) begin
              wordAcc  <= {wordAcc[WORD_BITS-9:0], rxShift};
              wordByte <= wordByte + 1'b1;
              if (wordByte == WB_LAST) begin
                wordByte  <= '0;
                dataWord  <= {wordAcc[WORD_BITS-9:0], rxShift};
                dataDev   <= devIdx;
                dataValid <= 1'b1;
                devIdx    <= devIdx + 1'b1;
              end
            end else if (kindR == FR_READ && byteIdx > HDR_LAST) begin
              rbAcc <= {rbAcc[RB_BITS-9:0], rxShift};
              if (byteIdx == lastByte) begin
                rbValid <= 1'b1;
                rbError <= (rbAcc[RB_BITS-9 -: 8] != RB_FIRST_GOOD);
              end
            end
            if (byteIdx == lastByte) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              byteIdx <= byteIdx + 1'b1;
              txShift <= txByte(kindR, byteIdx + 1'b1);
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/adc_chain_seq.sv
module adc_chain_seq
  import adc_chain_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int RESET_HOLD = 20,
  parameter int RESET_WAIT = 15,
  parameter int CMD_GAP    = 6,
  parameter int FIRST_EDGE = 8,
  parameter int DEVICES    = 2,
  parameter int WORD_BITS  = 32,
  parameter int RB_BYTES   = 8,
  parameter int DEV_W      = DEVICES > 1 ? $clog2(DEVICES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  softRestart,
  output logic                  sclk,
  output logic                  mosi,
  input  logic                  miso,
  output logic                  csN,
  output logic                  adcResetN,
  output logic                  adcStart,
  input  logic                  drdyN,
  output logic [WORD_BITS-1:0]  dataWord,
  output logic [DEV_W-1:0]      dataDev,
  output logic                  dataValid,
  output logic [8*RB_BYTES-1:0] rbData,
  output logic                  rbValid,
  output logic                  rbError,
  output logic                  overrun
);

  ctrlStrobe_t strobe;
  logic        frameDone;

  adc_chain_ctrl #(
    .RESET_HOLD(RESET_HOLD), .RESET_WAIT(RESET_WAIT),
    .CMD_GAP(CMD_GAP), .FIRST_EDGE(FIRST_EDGE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .softRestart(softRestart), .drdyN(drdyN),
    .done(frameDone), .strobe(strobe), .adcResetN(adcResetN),
    .adcStart(adcStart), .csN(csN), .overrun(overrun)
  );

  adc_chain_dp #(
    .HALF_DIV(HALF_DIV), .DEVICES(DEVICES), .WORD_BITS(WORD_BITS),
    .RB_BYTES(RB_BYTES), .DEV_W(DEV_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .miso(miso), .sclk(sclk),
    .mosi(mosi), .done(frameDone), .dataWord(dataWord), .dataDev(dataDev),
    .dataValid(dataValid), .rbData(rbData), .rbValid(rbValid), .rbError(rbError)
  );

endmodule

// File: rtl/adc_chain_chk.sv
module adc_chain_chk (
  input logic clk,
  input logic rstN,
  input logic softRestart,
  input logic sclk,
  input logic mosi,
  input logic adcResetN,
  input logic adcStart,
  input logic dataValid,
  input logic rbValid,
  input logic rbError,
  input logic overrun
);

  // R1
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !adcResetN |-> (!adcStart && !sclk));

  // R4
  rb_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rbError |-> rbValid);

  // R5
  capture_needs_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> adcStart);

  // R8
  mosi_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !softRestart) |=> overrun);

  // R11
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    softRestart |=> (!adcResetN && !adcStart && !overrun && !rbValid));

endmodule

bind adc_chain_seq adc_chain_chk u_chk (
  .clk(clk), .rstN(rstN), .softRestart(softRestart), .sclk(sclk), .mosi(mosi),
  .adcResetN(adcResetN), .adcStart(adcStart), .dataValid(dataValid),
  .rbValid(rbValid), .rbError(rbError), .overrun(overrun)
);

// File: tb/tb_adc_chain_seq.sv
module tb_adc_chain_seq;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 2;
  localparam int RESET_HOLD = 20;
  localparam int RESET_WAIT = 15;
  localparam int CMD_GAP    = 6;
  localparam int FIRST_EDGE = 8;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRestart = 1'b0;
  logic        sclk, mosi, csN, adcResetN, adcStart;
  logic        miso;
  logic        drdyN = 1'b1;
  logic [31:0] dataWord;
  logic [0:0]  dataDev;
  logic        dataValid;
  logic [63:0] rbData;
  logic        rbValid, rbError, overrun;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  adc_chain_seq #(
    .HALF_DIV(HALF_DIV), .RESET_HOLD(RESET_HOLD), .RESET_WAIT(RESET_WAIT),
    .CMD_GAP(CMD_GAP), .FIRST_EDGE(FIRST_EDGE)
  ) dut (
    .clk(clk), .rstN(rstN), .softRestart(softRestart), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csN(csN), .adcResetN(adcResetN), .adcStart(adcStart),
    .drdyN(drdyN), .dataWord(dataWord), .dataDev(dataDev), .dataValid(dataValid),
    .rbData(rbData), .rbValid(rbValid), .rbError(rbError), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, bit ok, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // chain model
  int          frameNo = 0;
  int          bitNo = 0;
  int          risesInFrame = 0;
  bit          mosiHigh = 0;
  bit          holdLow = 0;
  logic [79:0] rbResp = 80'hFFFF_8301_0203_0405_8040;
  logic [63:0] dataResp = '0;
  logic [79:0] mosiCap = '0;

  function automatic int frameLen(int f);
    return (f == 0) ? 24 : (f == 1) ? 80 : 64;
  endfunction

  always_comb begin
    if (frameNo == 1 && bitNo < 80)      miso = rbResp[79 - bitNo];
    else if (frameNo >= 2 && bitNo < 64) miso = dataResp[63 - bitNo];
    else                                 miso = 1'b0;
  end

  always @(posedge sclk) begin
    mosiCap = {mosiCap[78:0], mosi};
    risesInFrame++;
    if (frameNo >= 2 && mosi) mosiHigh = 1;
    if (frameNo >= 2 && !holdLow) drdyN = 1'b1;
  end

  always @(negedge sclk) begin
    bitNo++;
    if (bitNo == frameLen(frameNo)) begin
      if (frameNo == 0) check("R2 write frame bytes", mosiCap[23:0] == 24'h410001,
                              longint'(mosiCap[23:0]), 24'h410001);
      else if (frameNo == 1) check("R3 readback frame bytes",
                                   mosiCap == {16'h2007, 64'h0},
                                   longint'(mosiCap[79:64]), 16'h2007);
      else begin
        check("R7 rising edges per frame", risesInFrame == 64, risesInFrame, 64);
        check("R7 mosi low in capture", !mosiHigh, mosiHigh, 0);
      end
      frameNo++;
      bitNo = 0;
      risesInFrame = 0;
      mosiHigh = 0;
    end
  end

  // R8 high-phase width
  int highRun = 0;
  int widthChecks = 0;
  always @(negedge clk) begin
    if (sclk) highRun++;
    else begin
      if (highRun != 0 && widthChecks < 3) begin
        widthChecks++;
        check("R8 sclk high phase", highRun == HALF_DIV, highRun, HALF_DIV);
      end
      highRun = 0;
    end
  end

  // scoreboard
  logic [32:0] expQ[$];

  always @(negedge clk) begin
    if (rstN && dataValid) begin
      if (expQ.size() == 0) begin
        check("R9 unexpected word", 0, {dataDev, dataWord}, 0);
      end else begin
        logic [32:0] e;
        e = expQ.pop_front();
        check("R9 word and position", {dataDev, dataWord} == e,
              longint'({dataDev, dataWord}), longint'(e));
      end
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      check("watchdog", 0, cycles, WATCHDOG);
      finishRun();
    end
  end

  task automatic captureFrame(logic [31:0] w0, logic [31:0] w1, bit early);
    int f0, delay;
    f0 = frameNo;
    @(negedge clk);
    dataResp = {w0, w1};
    expQ.push_back({1'b0, w0});
    expQ.push_back({1'b1, w1});
    drdyN = 1'b0;
    delay = 0;
    while (!sclk) begin
      @(negedge clk);
      delay++;
    end
    check("R6 first edge delay",
          delay >= FIRST_EDGE && delay <= FIRST_EDGE + HALF_DIV + 4, delay, FIRST_EDGE);
    if (early) begin
      repeat (40) @(negedge clk);
      holdLow = 1;
      drdyN = 1'b0;
      repeat (5) @(negedge clk);
      drdyN = 1'b1;
      holdLow = 0;
    end
    wait (frameNo == f0 + 1);
    repeat (6) @(negedge clk);
  endtask

  task automatic runConfig(bit expErr, logic [63:0] expRb);
    int n;
    n = 0;
    while (!adcResetN) begin
      @(negedge clk);
      n++;
    end
    check("R1 reset hold length", n >= RESET_HOLD - 1 && n <= RESET_HOLD + 1, n, RESET_HOLD);
    check("R1 start low at release", !adcStart && csN == 1'b0, {adcStart, csN}, 0);
    check("R1 no clocking during hold", frameNo == 0 && bitNo == 0 && risesInFrame == 0,
          risesInFrame, 0);
    n = 0;
    while (!sclk) begin
      @(negedge clk);
      n++;
    end
    check("R1 settle before first sclk", n >= RESET_WAIT, n, RESET_WAIT);
    wait (rbValid === 1'b1);
    @(negedge clk);
    check("R3 readback data", rbData == expRb, longint'(rbData), longint'(expRb));
    check("R4 readback error flag", rbError == expErr, rbError, expErr);
    check("R5 start low until dump done", !adcStart || frameNo == 2, adcStart, 0);
    wait (adcStart === 1'b1);
    @(negedge clk);
    check("R5 start after both commands", frameNo == 2 && rbValid, frameNo, 2);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", !adcResetN && !adcStart && !sclk && !dataValid && !overrun,
          {adcResetN, adcStart, sclk}, 0);
    rstN = 1'b1;
    runConfig(1'b0, 64'h8301_0203_0405_8040);

    captureFrame(32'h12345678, 32'h9ABCDEF0, 0);
    captureFrame(32'hFFFFFF00, 32'h00000001, 0);
    captureFrame(32'hA5A5A5C3, 32'h5A5A5A3C, 0);
    check("R10 no overrun on clean frames", !overrun, overrun, 0);
    check("R5 start held in capture", adcStart, adcStart, 1);

    captureFrame(32'h0F0F0F11, 32'hF0F0F022, 1);
    check("R10 overrun set", overrun, overrun, 1);
    repeat (20) @(negedge clk);
    check("R10 overrun sticky", overrun, overrun, 1);
    check("R10 words intact", expQ.size() == 0, expQ.size(), 0);

    rbResp = 80'hFFFF_0001_0203_0405_8040;
    softRestart = 1'b1;
    frameNo = 0;
    bitNo = 0;
    risesInFrame = 0;
    @(negedge clk);
    softRestart = 1'b0;
    check("R11 restart clears", !adcResetN && !adcStart && !overrun && !rbValid && !rbError,
          {adcResetN, adcStart, overrun, rbValid, rbError}, 0);
    runConfig(1'b1, 64'h0001_0203_0405_8040);
    captureFrame(32'h00C0FFEE, 32'h7EADBE01, 0);
    check("R11 capture resumes", expQ.size() == 0 && !overrun, expQ.size(), 0);
    finishRun();
  end

endmodule